// File: doc/BRIEF.md
# Per-Thread Commit Squash Controller

This block keeps the commit-side status of up to four hardware threads and produces the squash broadcast that earlier pipeline stages use to discard wrong-path work. It takes three kinds of squash cause. The first is a squash request from the execute stage, carrying a sequence number. The second is a delayed trap: after a trap request, the thread waits a programmable number of cycles before it is flushed. The third is an external context squash that flushes the whole thread at once.

For each thread the block records the youngest sequence number that the reorder buffer has accepted. It uses this value to reject execute squashes that point past any live instruction. A squashed thread stays in the squashing state, and keeps telling the front end that the reorder buffer is still squashing, until the reorder buffer reports that it has finished. Instructions from rename are admitted to the reorder buffer only when they pass this block's filter. Reorder buffer storage, the rename map and trap execution are outside the block and appear only as ports.

Top module: `csq_top`

## Requirements
- R1: After reset every thread is Idle, its youngest sequence number is 0, and no squash output is asserted.
- R2: A thread's state is reported on `th_state` as Idle=0, Running=1, Squashing=2, TrapPending=3 or FetchTrapPending=4. The first accepted insertion into an Idle thread makes it Running.
- R3: A rename insertion (`ins_tid` selects the thread) is accepted only if `ins_killed` is low, no squash is taken for that thread in the same cycle, and the thread is not still squashing. An accepted insertion sets the youngest sequence number to `ins_seq`. A refused insertion changes nothing.
- R4: An execute squash is taken only if the thread is not in TrapPending and its sequence number is less than or equal to the thread's youngest sequence number. A refused squash leaves every output unchanged.
- R5: A taken execute squash uses the given sequence number, minus one when `exs_incl` is set, as its squash point. That point becomes both the youngest sequence number and `bc_done_seq`. The redirect PC, the mispredict flag and the taken flag are copied from the request, and the thread enters Squashing.
- R6: A trap request made while the thread is Idle or Running, with no squash in that cycle, enters TrapPending. A fetch-trap request enters FetchTrapPending; when both arrive together the trap request wins. The thread-wide squash pulse appears L+1 clock edges after the edge that captured the request, where L is `trap_lat` or `ftrap_lat` as sampled at that edge.
- R7: A thread-wide squash (an expired trap timer or `ctx_sq_req`) sets `bc_done_seq` to the head sequence number minus one, or to 0 if the reorder buffer is empty. It also clears the youngest sequence number, clears the mispredict and taken flags, redirects to `restart_pc` and enters Squashing.
- R8: When a trap expires in the same cycle as a context squash or an execute squash for the same thread, exactly one squash is taken, and it is the thread-wide one.
- R9: A squashing thread returns to Running only in a cycle in which `rob_sq_done` is high. Until then `bc_rob_sq` is high in every cycle.
- R10: `bc_squash` is high for exactly one cycle per taken squash. `bc_done_seq`, `bc_pc`, `bc_mispred` and `bc_taken` hold their values between squashes.
- R11: Any squash taken while a trap or fetch trap is pending cancels the pending timer, so no later thread-wide squash follows from it. An execute squash is accepted in FetchTrapPending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exs_valid | input | NT | Execute squash request per thread |
| exs_seq | input | NT x SEQ_W | Execute squash sequence number |
| exs_incl | input | NT | Also squash the named instruction |
| exs_mispred | input | NT | Branch mispredict flag of the request |
| exs_taken | input | NT | Branch taken flag of the request |
| exs_target | input | NT x PC_W | Redirect PC of the request |
| trap_req | input | NT | Start a trap delay |
| ftrap_req | input | NT | Start a fetch-trap delay |
| trap_lat | input | LAT_W | Trap delay in cycles |
| ftrap_lat | input | LAT_W | Fetch-trap delay in cycles |
| ctx_sq_req | input | NT | Immediate thread-wide squash |
| rob_empty | input | NT | Reorder buffer holds nothing for the thread |
| rob_head_seq | input | NT x SEQ_W | Sequence number at the reorder buffer head |
| restart_pc | input | NT x PC_W | PC at which a thread-wide squash restarts |
| rob_sq_done | input | NT | Reorder buffer finished squashing |
| ins_valid | input | 1 | Rename offers an instruction |
| ins_tid | input | TID_W | Thread of the offered instruction |
| ins_seq | input | SEQ_W | Sequence number of the offered instruction |
| ins_killed | input | 1 | Offered instruction is already squashed |
| bc_squash | output | NT | Squash pulse per thread |
| bc_rob_sq | output | NT | Reorder buffer still squashing |
| bc_done_seq | output | NT x SEQ_W | Squash point of the last squash |
| bc_pc | output | NT x PC_W | Redirect PC of the last squash |
| bc_mispred | output | NT | Mispredict flag of the last squash |
| bc_taken | output | NT | Taken flag of the last squash |
| th_state | output | NT x 3 | Thread state code |
| th_youngest | output | NT x SEQ_W | Youngest accepted sequence number |

## Verification
Three pairs of events can land in the same cycle for one thread: a trap timer expiring together with a context squash or an execute squash, and a rename insertion together with the `rob_sq_done` that ends squashing. The directed part of the bench puts a context squash and an execute squash exactly on the expiry edge of a trap, then checks that only one pulse is produced and that it carries the thread-wide values. The random part raises reorder-buffer completion, insertions and squashes together at high rates, and compares every output of every thread on every clock against a reference model that applies the priority rules event by event.

// File: rtl/csq_pkg.sv
package csq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_ROBSQ = 3'd2,
    ST_TRAP  = 3'd3,
    ST_FTRAP = 3'd4
  } thr_state_e;

  // Squash point of an execute-stage request.
  function automatic logic [15:0] ex_point(input logic [15:0] seq, input logic incl);
    return incl ? seq - 16'd1 : seq;
  endfunction

  // Squash point of a thread-wide flush.
  function automatic logic [15:0] flush_point(input logic empty, input logic [15:0] head);
    return empty ? 16'd0 : head - 16'd1;
  endfunction

endpackage

// File: rtl/csq_trap_timer.sv
module csq_trap_timer #(
  parameter int LAT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LAT_W-1:0] load_val,
  input  logic             cancel,
  output logic             armed,
  output logic             fire
);
  logic [LAT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (load) begin
      armed <= 1'b1;
      cnt   <= load_val;
    end else if (cancel) begin
      armed <= 1'b0;
    end else if (armed && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign fire = armed && (cnt == '0);
endmodule

// File: rtl/csq_thread.sv
module csq_thread
  import csq_pkg::*;
#(
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  parameter int LAT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ex_valid,
  input  logic [SEQ_W-1:0] ex_seq,
  input  logic             ex_incl,
  input  logic             ex_mis,
  input  logic             ex_tak,
  input  logic [PC_W-1:0]  ex_pc,
  input  logic             trap_req,
  input  logic             ftrap_req,
  input  logic [LAT_W-1:0] trap_lat,
  input  logic [LAT_W-1:0] ftrap_lat,
  input  logic             ctx_req,
  input  logic             rob_empty,
  input  logic [SEQ_W-1:0] head_seq,
  input  logic [PC_W-1:0]  restart_pc,
  input  logic             rob_done,
  input  logic             ins_hit,
  input  logic             ins_killed,
  input  logic [SEQ_W-1:0] ins_seq,
  output logic             sq_o,
  output logic             rsq_o,
  output logic [SEQ_W-1:0] done_o,
  output logic [PC_W-1:0]  pc_o,
  output logic             mis_o,
  output logic             tak_o,
  output thr_state_e       state_o,
  output logic [SEQ_W-1:0] young_o
);
  thr_state_e       st_live, st_nxt;
  logic             tmr_fire, tmr_armed, tmr_load;
  logic             whole_sq, ex_ok, any_sq, trap_ok, ftrap_ok, ins_ok;
  logic [SEQ_W-1:0] pt_ex, pt_flush;

  assign st_live  = (state_o == ST_ROBSQ && rob_done) ? ST_RUN : state_o;
  assign whole_sq = tmr_fire || ctx_req;
  assign ex_ok    = !whole_sq && ex_valid && st_live != ST_TRAP && ex_seq <= young_o;
  assign any_sq   = whole_sq || ex_ok;
  assign trap_ok  = !any_sq && trap_req  && (st_live == ST_IDLE || st_live == ST_RUN);
  assign ftrap_ok = !any_sq && !trap_req && ftrap_req && (st_live == ST_IDLE || st_live == ST_RUN);
  assign ins_ok   = ins_hit && !ins_killed && !any_sq && st_live != ST_ROBSQ;
  assign tmr_load = trap_ok || ftrap_ok;
  assign pt_ex    = ex_point(ex_seq, ex_incl);
  assign pt_flush = flush_point(rob_empty, head_seq);

  csq_trap_timer #(.LAT_W(LAT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load),
    .load_val(trap_ok ? trap_lat : ftrap_lat),
    .cancel(any_sq), .armed(tmr_armed), .fire(tmr_fire)
  );

  always_comb begin
    if (any_sq)                            st_nxt = ST_ROBSQ;
    else if (trap_ok)                      st_nxt = ST_TRAP;
    else if (ftrap_ok)                     st_nxt = ST_FTRAP;
    else if (ins_ok && st_live == ST_IDLE) st_nxt = ST_RUN;
    else                                   st_nxt = st_live;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_o <= ST_IDLE;
      young_o <= '0;
      sq_o    <= 1'b0;
      done_o  <= '0;
      pc_o    <= '0;
      mis_o   <= 1'b0;
      tak_o   <= 1'b0;
    end else begin
      state_o <= st_nxt;
      sq_o    <= any_sq;
      if (whole_sq) begin
        young_o <= '0;
        done_o  <= pt_flush;
        pc_o    <= restart_pc;
        mis_o   <= 1'b0;
        tak_o   <= 1'b0;
      end else if (ex_ok) begin
        young_o <= pt_ex;
        done_o  <= pt_ex;
        pc_o    <= ex_pc;
        mis_o   <= ex_mis;
        tak_o   <= ex_tak;
      end else if (ins_ok) begin
        young_o <= ins_seq;
      end
    end
  end

  assign rsq_o = (state_o == ST_ROBSQ);

  // Execute squash refused while a trap is pending (R4)
  p_trap_blocks_ex_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_TRAP && ex_valid && !whole_sq) |=> !sq_o);
  // Squash point carried to done and youngest (R5)
  p_ex_point_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_ok && !ex_incl) |=> (done_o == $past(ex_seq) && young_o == $past(ex_seq)));
  // Thread-wide squash values (R7)
  p_whole_vals_r7: assert property (@(posedge clk) disable iff (!rst_n)
    whole_sq |=> (young_o == '0 && !mis_o && !tak_o && pc_o == $past(restart_pc)));
  // Squashing held until the buffer reports done (R9)
  p_hold_sq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_ROBSQ && !rob_done) |=> state_o == ST_ROBSQ);
  // Insertion refused while still squashing (R3)
  p_ins_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_hit && state_o == ST_ROBSQ && !rob_done) |=> ($stable(young_o) || sq_o));
  // A running timer belongs to a pending state (R11)
  p_timer_owner_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_armed |-> (state_o == ST_TRAP || state_o == ST_FTRAP));
  // A squash pulse always comes with the squashing flag (R10)
  p_pulse_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sq_o |-> rsq_o);
endmodule

// File: rtl/csq_top.sv
module csq_top
  import csq_pkg::*;
#(
  parameter int NT    = 4,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  parameter int LAT_W = 6,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NT-1:0]              exs_valid,
  input  logic [NT-1:0][SEQ_W-1:0]   exs_seq,
  input  logic [NT-1:0]              exs_incl,
  input  logic [NT-1:0]              exs_mispred,
  input  logic [NT-1:0]              exs_taken,
  input  logic [NT-1:0][PC_W-1:0]    exs_target,
  input  logic [NT-1:0]              trap_req,
  input  logic [NT-1:0]              ftrap_req,
  input  logic [LAT_W-1:0]           trap_lat,
  input  logic [LAT_W-1:0]           ftrap_lat,
  input  logic [NT-1:0]              ctx_sq_req,
  input  logic [NT-1:0]              rob_empty,
  input  logic [NT-1:0][SEQ_W-1:0]   rob_head_seq,
  input  logic [NT-1:0][PC_W-1:0]    restart_pc,
  input  logic [NT-1:0]              rob_sq_done,
  input  logic                       ins_valid,
  input  logic [TID_W-1:0]           ins_tid,
  input  logic [SEQ_W-1:0]           ins_seq,
  input  logic                       ins_killed,
  output logic [NT-1:0]              bc_squash,
  output logic [NT-1:0]              bc_rob_sq,
  output logic [NT-1:0][SEQ_W-1:0]   bc_done_seq,
  output logic [NT-1:0][PC_W-1:0]    bc_pc,
  output logic [NT-1:0]              bc_mispred,
  output logic [NT-1:0]              bc_taken,
  output logic [NT-1:0][2:0]         th_state,
  output logic [NT-1:0][SEQ_W-1:0]   th_youngest
);
  for (genvar g = 0; g < NT; g++) begin : g_thr
    thr_state_e st;
    logic       hit;
    assign hit         = ins_valid && (ins_tid == TID_W'(g));
    assign th_state[g] = st;

    csq_thread #(.SEQ_W(SEQ_W), .PC_W(PC_W), .LAT_W(LAT_W)) u_thr (
      .clk(clk), .rst_n(rst_n),
      .ex_valid(exs_valid[g]), .ex_seq(exs_seq[g]), .ex_incl(exs_incl[g]),
      .ex_mis(exs_mispred[g]), .ex_tak(exs_taken[g]), .ex_pc(exs_target[g]),
      .trap_req(trap_req[g]), .ftrap_req(ftrap_req[g]),
      .trap_lat(trap_lat), .ftrap_lat(ftrap_lat), .ctx_req(ctx_sq_req[g]),
      .rob_empty(rob_empty[g]), .head_seq(rob_head_seq[g]),
      .restart_pc(restart_pc[g]), .rob_done(rob_sq_done[g]),
      .ins_hit(hit), .ins_killed(ins_killed), .ins_seq(ins_seq),
      .sq_o(bc_squash[g]), .rsq_o(bc_rob_sq[g]), .done_o(bc_done_seq[g]),
      .pc_o(bc_pc[g]), .mis_o(bc_mispred[g]), .tak_o(bc_taken[g]),
      .state_o(st), .young_o(th_youngest[g])
    );
  end
endmodule

// File: tb/tb_csq_top.sv
`timescale 1ns/1ps
module tb_csq_top;
  localparam int NT = 4, SW = 16, PW = 32, LW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NT-1:0] exs_valid, exs_incl, exs_mispred, exs_taken, trap_req, ftrap_req;
  logic [NT-1:0] ctx_sq_req, rob_empty, rob_sq_done;
  logic [NT-1:0][SW-1:0] exs_seq, rob_head_seq;
  logic [NT-1:0][PW-1:0] exs_target, restart_pc;
  logic [LW-1:0] trap_lat, ftrap_lat;
  logic ins_valid, ins_killed;
  logic [1:0] ins_tid;
  logic [SW-1:0] ins_seq;
  logic [NT-1:0] bc_squash, bc_rob_sq, bc_mispred, bc_taken;
  logic [NT-1:0][SW-1:0] bc_done_seq, th_youngest;
  logic [NT-1:0][PW-1:0] bc_pc;
  logic [NT-1:0][2:0] th_state;

  csq_top dut (.*);

  int tests = 0, fails = 0, cycles = 0;
  // reference model
  int m_st[NT], m_yg[NT], m_cnt[NT], m_done[NT];
  bit m_arm[NT], m_sq[NT], m_mis[NT], m_tak[NT];
  longint m_pc[NT];
  int seqgen[NT];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic clr();
    exs_valid = '0; exs_incl = '0; exs_mispred = '0; exs_taken = '0; exs_seq = '0;
    exs_target = '0; trap_req = '0; ftrap_req = '0; ctx_sq_req = '0;
    rob_sq_done = '0; ins_valid = 0; ins_killed = 0; ins_tid = '0; ins_seq = '0;
  endtask

  // Behavioural next-state of the model, from its own variables and the inputs.
  task automatic model();
    for (int t = 0; t < NT; t++) begin
      int now;
      bit expired, take_all, take_ex;
      now = m_st[t];
      if (now == 2 && rob_sq_done[t]) now = 1;
      expired  = m_arm[t] && m_cnt[t] == 0;
      take_all = expired || ctx_sq_req[t];
      take_ex  = !take_all && exs_valid[t] && now != 3 && int'(exs_seq[t]) <= m_yg[t];
      m_sq[t] = take_all || take_ex;
      if (take_all) begin
        m_done[t] = rob_empty[t] ? 0 : (int'(rob_head_seq[t]) + 65535) % 65536;
        m_yg[t] = 0; m_pc[t] = restart_pc[t]; m_mis[t] = 0; m_tak[t] = 0;
      end else if (take_ex) begin
        m_done[t] = exs_incl[t] ? (int'(exs_seq[t]) + 65535) % 65536 : int'(exs_seq[t]);
        m_yg[t] = m_done[t]; m_pc[t] = exs_target[t];
        m_mis[t] = exs_mispred[t]; m_tak[t] = exs_taken[t];
      end
      if (m_sq[t]) begin
        now = 2; m_arm[t] = 0;
      end else if ((now == 0 || now == 1) && trap_req[t]) begin
        now = 3; m_arm[t] = 1; m_cnt[t] = trap_lat;
      end else if ((now == 0 || now == 1) && ftrap_req[t]) begin
        now = 4; m_arm[t] = 1; m_cnt[t] = ftrap_lat;
      end else if (m_arm[t] && m_cnt[t] > 0) m_cnt[t]--;
      if (ins_valid && int'(ins_tid) == t && !ins_killed && now != 2) begin
        m_yg[t] = ins_seq;
        if (now == 0) now = 1;
      end
      m_st[t] = now;
    end
  endtask

  task automatic compare();
    for (int t = 0; t < NT; t++) begin
      chk(bc_squash[t] == m_sq[t], "R10 pulse", bc_squash[t], m_sq[t]);
      chk(int'(th_state[t]) == m_st[t], "R2|R6|R9 state", th_state[t], m_st[t]);
      chk(bc_rob_sq[t] == (m_st[t] == 2), "R9 rob_sq", bc_rob_sq[t], m_st[t] == 2);
      chk(int'(th_youngest[t]) == m_yg[t], "R3|R5 youngest", th_youngest[t], m_yg[t]);
      chk(int'(bc_done_seq[t]) == m_done[t], "R5|R7 done_seq", bc_done_seq[t], m_done[t]);
      chk(longint'(bc_pc[t]) == m_pc[t], "R5|R7 pc", bc_pc[t], m_pc[t]);
      chk(bc_mispred[t] == m_mis[t] && bc_taken[t] == m_tak[t], "R7 flags",
          {bc_mispred[t], bc_taken[t]}, {m_mis[t], m_tak[t]});
    end
  endtask

  task automatic step();
    model();
    @(posedge clk); #1;
    cycles++;
    compare();
    clr();
  endtask

  task automatic insert(input int t, input int s);
    ins_valid = 1; ins_tid = 2'(t); ins_seq = 16'(s); step();
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    clr();
    trap_lat = 6'd3; ftrap_lat = 6'd1;
    rob_empty = '0;
    for (int t = 0; t < NT; t++) begin
      rob_head_seq[t] = 16'(100 + t); restart_pc[t] = 32'h1000 * (t + 1);
      m_st[t] = 0; m_yg[t] = 0; m_cnt[t] = 0; m_done[t] = 0; m_arm[t] = 0;
      m_sq[t] = 0; m_mis[t] = 0; m_tak[t] = 0; m_pc[t] = 0; seqgen[t] = 1;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int t = 0; t < NT; t++)
      chk(th_state[t] == 3'd0 && th_youngest[t] == '0 && !bc_squash[t] && !bc_rob_sq[t],
          "R1 reset", {th_state[t], th_youngest[t]}, 0);

    // R2/R3: insertion into idle thread 0
    insert(0, 10);
    chk(th_state[0] == 3'd1, "R2 idle->run", th_state[0], 1);
    // R4: too-young squash ignored
    exs_valid[0] = 1; exs_seq[0] = 16'd11; step();
    chk(!bc_squash[0] && th_youngest[0] == 16'd10, "R4 stale ignored", th_youngest[0], 10);
    // R5: boundary equal, include flag
    exs_valid[0] = 1; exs_seq[0] = 16'd10; exs_incl[0] = 1; exs_mispred[0] = 1;
    exs_target[0] = 32'hABCD; step();
    chk(bc_done_seq[0] == 16'd9 && th_youngest[0] == 16'd9, "R5 point", bc_done_seq[0], 9);
    // R3: insert while squashing refused; R9 hold
    insert(0, 20);
    chk(th_youngest[0] == 16'd9 && bc_rob_sq[0], "R3 refused", th_youngest[0], 9);
    // R9: done together with an insertion
    rob_sq_done[0] = 1; ins_valid = 1; ins_tid = 2'd0; ins_seq = 16'd21; step();
    chk(th_state[0] == 3'd1 && th_youngest[0] == 16'd21, "R9 resume", th_state[0], 1);

    // R6: trap timing on thread 1 with L=3
    insert(1, 50);
    trap_req[1] = 1; ftrap_req[1] = 1; step();
    chk(th_state[1] == 3'd3, "R6 trap wins", th_state[1], 3);
    for (int k = 0; k < 3; k++) begin
      // R4: execute squash refused in TrapPending
      exs_valid[1] = 1; exs_seq[1] = 16'd40; step();
      chk(!bc_squash[1], "R6 early pulse", bc_squash[1], 0);
    end
    // R8: expiry edge with a context squash and an execute squash
    ctx_sq_req[1] = 1; exs_valid[1] = 1; exs_seq[1] = 16'd1; step();
    chk(bc_squash[1] && bc_done_seq[1] == 16'd100 && th_youngest[1] == 0, "R8 single wide squash",
        bc_done_seq[1], 100);
    rob_sq_done[1] = 1; step();
    step();
    chk(!bc_squash[1], "R8 no second pulse", bc_squash[1], 0);

    // R11: context squash cancels a pending trap on thread 2
    insert(2, 7);
    trap_req[2] = 1; step();
    rob_empty[2] = 1; ctx_sq_req[2] = 1; step();
    chk(bc_done_seq[2] == 16'd0, "R7 empty point", bc_done_seq[2], 0);
    rob_sq_done[2] = 1; step();
    for (int k = 0; k < 6; k++) begin
      step();
      chk(!bc_squash[2], "R11 cancelled", bc_squash[2], 0);
    end
    // R11: execute squash accepted in FetchTrapPending
    insert(3, 30);
    ftrap_req[3] = 1; step();
    exs_valid[3] = 1; exs_seq[3] = 16'd30; step();
    chk(bc_squash[3] && th_state[3] == 3'd2, "R11 ex in ftrap", th_state[3], 2);
    rob_empty = '0;

    // random phase
    for (int n = 0; n < 3000; n++) begin
      trap_lat = 6'($urandom_range(0, 5)); ftrap_lat = 6'($urandom_range(0, 5));
      for (int t = 0; t < NT; t++) begin
        exs_valid[t]   = ($urandom_range(0, 5) == 0);
        exs_seq[t]     = 16'(m_yg[t] + $urandom_range(0, 2) - 1);
        exs_incl[t]    = $urandom_range(0, 1);
        exs_mispred[t] = $urandom_range(0, 1);
        exs_taken[t]   = $urandom_range(0, 1);
        exs_target[t]  = $urandom;
        trap_req[t]    = ($urandom_range(0, 29) == 0);
        ftrap_req[t]   = ($urandom_range(0, 39) == 0);
        ctx_sq_req[t]  = ($urandom_range(0, 39) == 0);
        rob_sq_done[t] = ($urandom_range(0, 2) == 0);
        rob_empty[t]   = ($urandom_range(0, 3) == 0);
        rob_head_seq[t] = 16'($urandom);
        restart_pc[t]  = $urandom;
      end
      ins_valid = $urandom_range(0, 1);
      ins_tid = 2'($urandom_range(0, 3));
      ins_killed = ($urandom_range(0, 5) == 0);
      seqgen[ins_tid] = seqgen[ins_tid] + 1;
      ins_seq = 16'(seqgen[ins_tid]);
      step();
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule